// File: doc/BRIEF.md
# Load-Use Interlock and Operand Bypass Controller

This block controls data hazards in a five-stage in-order integer pipeline (fetch, decode, execute, memory access, write-back). Each cycle it takes the decode-stage instruction's source registers, destination and load flag. It keeps its own shadow of the destination, write-enable and load fields of the two older instructions now in execute and memory access. It compares the decode sources against those producers and decides how each ALU operand is fed once the instruction moves into execute. The operand can come from the register file, from the EX/MA result register, or from the MA/WB result register.

A read-after-write dependence on an ALU result is bypassed with no lost cycle. A dependence on a load that is still in execute cannot be bypassed in time. In that case the block raises `stall` for one cycle so that the PC and the IF/ID register hold, and raises `bubble` so that an empty slot enters ID/EX. Older instructions keep advancing. On the next cycle the held instruction is presented again and picks up the loaded value from the MA/WB register. The register file is assumed to return a value written in the same cycle, so a producer in write-back needs no bypass.

Top module: `hzd_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `stall` and `bubble` are 0 and both operand selects are 00, and no earlier instruction counts as a producer.
- R2: If a valid decode instruction uses a source that equals the destination of a non-load writing instruction now in execute, it does not stall, and on the next cycle that operand's select is 10 (EX/MA value).
- R3: If a used source matches only the writing instruction now in memory access, that operand's select is 01 (MA/WB value) on the next cycle.
- R4: If both the execute and the memory-access producers match the same source, the select is 10, so the younger result wins.
- R5: If a used source matches a writing load in execute, `stall` and `bubble` are 1 in that same cycle. When the held instruction is presented again on the next cycle, there is no stall, and its select is then 01.
- R6: The slot inserted during a stall carries no bypass: on the cycle after a stall, both selects are 00, and the slot never later acts as a producer.
- R7: Register index 0 never causes a bypass or a stall, whether as a source or as a destination.
- R8: A producer whose write-enable is 0 never causes a bypass or a stall, even if it is a load.
- R9: A source whose used flag is 0 never causes a bypass or a stall.
- R10: A decode slot with `id_valid` low never stalls, and it enters execute as an empty slot that later instructions do not bypass from.
- R11: A load that is two instructions ahead (in memory access) causes no stall and is bypassed with select 01.
- R12: The two operands are decided independently, so one instruction can get different selects on its two operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_rs1 | input | 5 | First source register index |
| id_rs1_used | input | 1 | First source is read |
| id_rs2 | input | 5 | Second source register index |
| id_rs2_used | input | 1 | Second source is read |
| id_rd | input | 5 | Destination register index |
| id_wen | input | 1 | Instruction writes its destination |
| id_is_load | input | 1 | Instruction is a memory load |
| stall | output | 1 | Hold PC and IF/ID this cycle |
| bubble | output | 1 | Insert an empty slot into ID/EX this cycle |
| opsel_a | output | 2 | Operand A source for the instruction in execute: 00 register file, 01 MA/WB, 10 EX/MA |
| opsel_b | output | 2 | Operand B source for the instruction in execute, same encoding |

## Verification
The assertions assume that the surrounding pipeline honours `stall`. While it is high, the same decode instruction must be presented again on the next cycle, and the decode inputs must be settled before each rising edge. The single-cycle stall property also relies on the block seeing every instruction that enters execute, so the block must never be bypassed by an external flush. The bench's driver task builds this in: whenever its own model expects a stall, it presents the held instruction again, and it changes inputs only on falling edges.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int RIDX_W = 5;
    localparam int NSRC   = 2;

    typedef logic [RIDX_W-1:0] ridx_t;

    // Destination tag of an in-flight producer
    typedef struct packed {
        logic  wen;
        logic  load;
        ridx_t rd;
    } prod_t;

    // Source operand of the decode-stage instruction
    typedef struct packed {
        logic  used;
        ridx_t idx;
    } src_t;

    typedef enum logic [1:0] {
        OPSEL_RF   = 2'b00,
        OPSEL_MAWB = 2'b01,
        OPSEL_EXMA = 2'b10
    } opsel_e;

    typedef opsel_e [NSRC-1:0] opsel_vec_t;

    localparam prod_t PROD_NONE = '0;

    function automatic logic src_hits(src_t s, prod_t p);
        return s.used && (s.idx != '0) && p.wen && (p.rd == s.idx);
    endfunction

endpackage

// File: rtl/hzd_src_cmp.sv
module hzd_src_cmp
    import hzd_pkg::*;
(
    input  src_t   src,
    input  prod_t  ex_p,
    input  prod_t  ma_p,
    output opsel_e sel,
    output logic   load_use
);

    logic hit_ex;
    logic hit_ma;

    always_comb begin
        hit_ex   = src_hits(src, ex_p);
        hit_ma   = src_hits(src, ma_p);
        load_use = hit_ex && ex_p.load;
        if (hit_ex)      sel = OPSEL_EXMA;
        else if (hit_ma) sel = OPSEL_MAWB;
        else             sel = OPSEL_RF;
    end

endmodule

// File: rtl/hzd_tag_pipe.sv
module hzd_tag_pipe
    import hzd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  kill,
    input  prod_t id_p,
    output prod_t ex_p,
    output prod_t ma_p
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_p <= PROD_NONE;
            ma_p <= PROD_NONE;
        end else begin
            ma_p <= ex_p;
            ex_p <= kill ? PROD_NONE : id_p;
        end
    end

endmodule

// File: rtl/hzd_sel_reg.sv
module hzd_sel_reg
    import hzd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       kill,
    input  opsel_vec_t sel_d,
    output opsel_vec_t sel_q
);

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            for (int i = 0; i < NSRC; i++) sel_q[i] <= OPSEL_RF;
        end else begin
            sel_q <= sel_d;
        end
    end

endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
    import hzd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                id_valid,
    input  logic [RIDX_W-1:0]   id_rs1,
    input  logic                id_rs1_used,
    input  logic [RIDX_W-1:0]   id_rs2,
    input  logic                id_rs2_used,
    input  logic [RIDX_W-1:0]   id_rd,
    input  logic                id_wen,
    input  logic                id_is_load,
    output logic                stall,
    output logic                bubble,
    output logic [1:0]          opsel_a,
    output logic [1:0]          opsel_b
);

    src_t       srcs [NSRC];
    prod_t      id_p;
    prod_t      ex_p;
    prod_t      ma_p;
    opsel_vec_t sel_d;
    opsel_vec_t sel_q;
    logic [NSRC-1:0] lu;
    logic       kill;

    assign srcs[0] = '{used: id_rs1_used, idx: id_rs1};
    assign srcs[1] = '{used: id_rs2_used, idx: id_rs2};
    assign id_p    = '{wen: id_wen, load: id_is_load, rd: id_rd};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hzd_src_cmp u_cmp (
            .src      (srcs[g]),
            .ex_p     (ex_p),
            .ma_p     (ma_p),
            .sel      (sel_d[g]),
            .load_use (lu[g])
        );
    end

    assign stall  = id_valid && (|lu);
    assign bubble = stall;
    assign kill   = stall || !id_valid;

    hzd_tag_pipe u_tags (
        .clk  (clk),
        .rst  (rst),
        .kill (kill),
        .id_p (id_p),
        .ex_p (ex_p),
        .ma_p (ma_p)
    );

    hzd_sel_reg u_sel (
        .clk   (clk),
        .rst   (rst),
        .kill  (kill),
        .sel_d (sel_d),
        .sel_q (sel_q)
    );

    assign opsel_a = sel_q[0];
    assign opsel_b = sel_q[1];

    // R5: an inserted slot can never produce a second back-to-back stall
    a_r5_single_stall: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    // R6: the slot entering execute during a stall carries no bypass
    a_r6_bubble_no_fwd: assert property (@(posedge clk) disable iff (rst)
        stall |=> (opsel_a == 2'b00 && opsel_b == 2'b00));

    // R2/R4: a matching producer in execute wins for operand A
    a_r4_ex_priority: assert property (@(posedge clk) disable iff (rst)
        (id_valid && !stall && id_rs1_used && id_rs1 != '0 &&
         ex_p.wen && ex_p.rd == id_rs1) |=> (opsel_a == 2'b10));

    // R7: source register 0 never selects a bypass
    a_r7_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (id_valid && id_rs1 == '0 && id_rs2 == '0) |=>
        (opsel_a == 2'b00 && opsel_b == 2'b00));

    // R8: with no writing producer in flight there is no stall
    a_r8_no_writer: assert property (@(posedge clk) disable iff (rst)
        (!ex_p.wen && !ma_p.wen) |-> !stall);

    // R10: an empty decode slot never stalls
    a_r10_invalid: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> !stall);

endmodule

// File: tb/hzd_unit_bench.sv
module hzd_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       id_valid = 1'b0;
    logic [4:0] id_rs1 = '0;
    logic       id_rs1_used = 1'b0;
    logic [4:0] id_rs2 = '0;
    logic       id_rs2_used = 1'b0;
    logic [4:0] id_rd = '0;
    logic       id_wen = 1'b0;
    logic       id_is_load = 1'b0;
    logic       stall;
    logic       bubble;
    logic [1:0] opsel_a;
    logic [1:0] opsel_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    // bench model of in-flight producers: {wen, load, rd}
    logic [6:0] m_ex = '0;
    logic [6:0] m_ma = '0;

    logic [3:0] q_sel [$];
    string      q_tag [$];

    always #5 clk = ~clk;

    hzd_unit u_hzd_unit (
        .clk(clk), .rst(rst), .id_valid(id_valid),
        .id_rs1(id_rs1), .id_rs1_used(id_rs1_used),
        .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
        .id_rd(id_rd), .id_wen(id_wen), .id_is_load(id_is_load),
        .stall(stall), .bubble(bubble), .opsel_a(opsel_a), .opsel_b(opsel_b)
    );

    task automatic check(string tag, string what, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic hit(logic [4:0] s, logic u, logic [6:0] p);
        return u && (s != 5'd0) && p[6] && (p[4:0] == s);
    endfunction

    function automatic logic [1:0] want_sel(logic [4:0] s, logic u);
        if (hit(s, u, m_ex)) return 2'b10;
        if (hit(s, u, m_ma)) return 2'b01;
        return 2'b00;
    endfunction

    // Driver: presents one instruction, re-presenting it while a stall is expected
    task automatic issue(logic v, logic [4:0] r1, logic u1, logic [4:0] r2, logic u2,
                         logic [4:0] rd, logic we, logic ld, string tag);
        logic exp_stall;
        do begin
            @(negedge clk);
            id_valid = v; id_rs1 = r1; id_rs1_used = u1; id_rs2 = r2;
            id_rs2_used = u2; id_rd = rd; id_wen = we; id_is_load = ld;
            #1;
            exp_stall = v && ((hit(r1, u1, m_ex) || hit(r2, u2, m_ex)) && m_ex[5]);
            check(tag, "stall", {3'b0, stall}, {3'b0, exp_stall});
            check(tag, "bubble", {3'b0, bubble}, {3'b0, exp_stall});
            if (exp_stall || !v) q_sel.push_back(4'b0000);
            else q_sel.push_back({want_sel(r1, u1), want_sel(r2, u2)});
            q_tag.push_back(exp_stall ? {tag, "/R6"} : tag);
            m_ma = m_ex;
            m_ex = (exp_stall || !v) ? 7'd0 : {we, ld, rd};
        end while (exp_stall);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) issue(1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, "idle");
    endtask

    // Monitor: pops the expected selects after each edge
    always @(posedge clk) begin
        if (mon_on && q_sel.size() > 0) begin
            logic [3:0] e;
            string t;
            #1;
            e = q_sel.pop_front();
            t = q_tag.pop_front();
            check(t, "opsel_a", {2'b0, opsel_a}, {2'b0, e[3:2]});
            check(t, "opsel_b", {2'b0, opsel_b}, {2'b0, e[1:0]});
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "stall in reset", {3'b0, stall}, 4'd0);
        check("R1", "bubble in reset", {3'b0, bubble}, 4'd0);
        check("R1", "opsel_a in reset", {2'b0, opsel_a}, 4'd0);
        check("R1", "opsel_b in reset", {2'b0, opsel_b}, 4'd0);
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;
        // R1: first instruction after reset sees no producer
        issue(1, 5'd3, 1, 5'd4, 1, 5'd5, 1, 0, "R1");

        idle(2);
        // R2: ALU result one ahead
        issue(1, 5'd1, 1, 5'd2, 1, 5'd5, 1, 0, "R2 prod");
        issue(1, 5'd5, 1, 5'd0, 0, 5'd6, 1, 0, "R2");
        idle(2);
        // R3: ALU result two ahead on operand B
        issue(1, 5'd1, 1, 5'd2, 1, 5'd6, 1, 0, "R3 prod");
        issue(1, 5'd1, 1, 5'd2, 1, 5'd20, 1, 0, "R3 gap");
        issue(1, 5'd3, 1, 5'd6, 1, 5'd7, 1, 0, "R3");
        idle(2);
        // R4: both stages write r8
        issue(1, 5'd1, 1, 5'd2, 1, 5'd8, 1, 0, "R4 old");
        issue(1, 5'd1, 1, 5'd2, 1, 5'd8, 1, 0, "R4 young");
        issue(1, 5'd8, 1, 5'd8, 1, 5'd9, 1, 0, "R4");
        idle(2);
        // R5/R6: load-use on operand A
        issue(1, 5'd1, 1, 5'd0, 0, 5'd9, 1, 1, "R5 load");
        issue(1, 5'd9, 1, 5'd2, 1, 5'd10, 1, 0, "R5");
        idle(2);
        // R5: load-use on both operands
        issue(1, 5'd1, 1, 5'd0, 0, 5'd15, 1, 1, "R5 load2");
        issue(1, 5'd15, 1, 5'd15, 1, 5'd16, 1, 0, "R5 both");
        idle(2);
        // R11: load two ahead
        issue(1, 5'd1, 1, 5'd0, 0, 5'd10, 1, 1, "R11 load");
        issue(1, 5'd1, 1, 5'd2, 1, 5'd21, 1, 0, "R11 gap");
        issue(1, 5'd10, 1, 5'd3, 1, 5'd22, 1, 0, "R11");
        idle(2);
        // R7: register 0
        issue(1, 5'd1, 1, 5'd2, 1, 5'd0, 1, 0, "R7 alu r0");
        issue(1, 5'd0, 1, 5'd0, 1, 5'd4, 1, 0, "R7");
        issue(1, 5'd1, 1, 5'd0, 0, 5'd0, 1, 1, "R7 load r0");
        issue(1, 5'd0, 1, 5'd0, 1, 5'd4, 1, 0, "R7 ld");
        idle(2);
        // R8: non-writing producers
        issue(1, 5'd1, 1, 5'd2, 1, 5'd11, 0, 0, "R8 nowr");
        issue(1, 5'd1, 1, 5'd11, 1, 5'd23, 0, 1, "R8");
        issue(1, 5'd11, 1, 5'd23, 1, 5'd24, 1, 0, "R8 ld");
        idle(2);
        // R9: unused source
        issue(1, 5'd1, 1, 5'd0, 0, 5'd12, 1, 1, "R9 load");
        issue(1, 5'd12, 0, 5'd12, 0, 5'd25, 1, 0, "R9");
        idle(2);
        // R10: invalid slots
        issue(0, 5'd1, 1, 5'd2, 1, 5'd13, 1, 0, "R10 inv");
        issue(1, 5'd13, 1, 5'd13, 1, 5'd26, 1, 0, "R10");
        issue(1, 5'd1, 1, 5'd0, 0, 5'd14, 1, 1, "R10 load");
        issue(0, 5'd14, 1, 5'd14, 1, 5'd27, 1, 0, "R10 nostall");
        idle(2);
        // R12: independent operands
        issue(1, 5'd1, 1, 5'd2, 1, 5'd16, 1, 0, "R12 a");
        issue(1, 5'd1, 1, 5'd2, 1, 5'd17, 1, 0, "R12 b");
        issue(1, 5'd16, 1, 5'd17, 1, 5'd18, 1, 0, "R12");
        idle(3);
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule